// File: doc/BRIEF.md
# Multi-Mode Overflow-Handling Adder

This block adds two WIDTH-bit words and deals with a result that does not fit in one of three ways, chosen per operation by a two-bit mode. In wrap mode it returns the sum modulo 2^WIDTH. In clamp mode it treats the operands as two's-complement values and pins a result that does not fit to the nearest end of the signed range. In poison mode the most-negative code (a one followed by zeros) is reserved as an error marker. The marker is produced by any overflow. It also passes through any addition that has the marker as an input, so an error survives a chain of adds.

Every result carries two raw flags whatever the mode. The first is the unsigned carry out of the top bit. The second is the signed overflow condition. Operands and mode enter on a valid/ready stream and results leave on another. With the default REG_OUT=1 there is a single output register. It takes a new item whenever it is empty or its current item is being consumed in the same cycle. While the consumer holds out_ready low, the held result does not change and in_ready stays low. With REG_OUT=0 the path is combinational: out_valid follows in_valid and in_ready follows out_ready.

Top module: `ovf_mode_adder`

## Requirements
- R1: With mode 2'b00 (wrap), and also with the unused code 2'b11, out_sum equals (op_a + op_b) mod 2^WIDTH. For WIDTH=4, 15+0 gives 15 and 15+15 gives 14.
- R2: In every mode, out_carry is 1 exactly when the unsigned sum op_a + op_b exceeds 2^WIDTH-1. The ripple chain has no carry input, so for WIDTH=4, 15+1 (that is, -1+1) gives carry 1.
- R3: In every mode, out_ovf is 1 exactly when the operands have equal sign bits (bit WIDTH-1) and the wrapped sum's sign bit differs from them. Operands of opposite sign never raise it, so -1+1 gives out_ovf 0.
- R4: With mode 2'b01 (clamp), a signed overflow with both operands non-negative gives 0 followed by all ones. One with both operands negative gives 1 followed by all zeros.
- R5: With mode 2'b10 (poison), out_sum is the marker (1 followed by WIDTH-1 zeros) whenever a signed overflow occurs, and also whenever the wrapped sum would itself equal the marker.
- R6: With mode 2'b10, if either operand equals the marker, out_sum is the marker whatever the other operand.
- R7: In clamp and poison modes, a result that none of the rules in R4 to R6 affects equals the wrapped sum.
- R8: After reset, out_valid is 0 and in_ready is 1.
- R9: With REG_OUT=1, an item accepted in one cycle (in_valid and in_ready both high) is presented with out_valid high from the next cycle. While out_valid is 1 and out_ready is 0, the outputs stay unchanged and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand item present |
| in_ready | output | 1 | Block can take an item this cycle |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| mode | input | 2 | 00 wrap, 01 clamp, 10 poison, 11 wrap |
| out_valid | output | 1 | Result item present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | WIDTH | Result word |
| out_carry | output | 1 | Raw unsigned carry out |
| out_ovf | output | 1 | Raw signed overflow |

## Verification
The hardest condition to reach from the ports is a poison-mode sum that lands exactly on the marker code without a signed overflow, for example -3 + -5 at WIDTH=4. It has to be told apart from the overflow case and from the marker-input case. The bench reaches it, and every other operand and mode pairing, by sweeping all 256 operand pairs in all four mode codes at WIDTH=4. On top of that it runs seeded random items and a directed stall that holds out_ready low while a second item waits.

// File: rtl/ovf_add_pkg.sv
package ovf_add_pkg;
  typedef enum logic [1:0] {
    MD_WRAP  = 2'b00,
    MD_CLAMP = 2'b01,
    MD_POISON = 2'b10,
    MD_SPARE = 2'b11
  } add_mode_t;

  typedef struct packed {
    logic carry;
    logic ovf;
  } add_flags_t;
endpackage

// File: rtl/ovf_ripple_core.sv
module ovf_ripple_core
  import ovf_add_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output add_flags_t       flags
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic p;
    assign p           = a[i] ^ b[i];
    assign sum[i]      = p ^ chain[i];
    assign chain[i+1]  = (a[i] & b[i]) | (p & chain[i]);
  end

  assign flags.carry = chain[WIDTH];
  assign flags.ovf   = (a[WIDTH-1] == b[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
endmodule

// File: rtl/ovf_mode_mux.sv
module ovf_mode_mux
  import ovf_add_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] raw,
  input  add_flags_t       flags,
  output logic [WIDTH-1:0] res
);
  localparam logic [WIDTH-1:0] NEG_END = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] POS_END = {1'b0, {(WIDTH-1){1'b1}}};

  logic poisoned;
  assign poisoned = (a == NEG_END) || (b == NEG_END) || flags.ovf || (raw == NEG_END);

  always_comb begin
    res = raw;
    case (add_mode_t'(mode))
      MD_CLAMP: begin
        if (flags.ovf) res = a[WIDTH-1] ? NEG_END : POS_END;
      end
      MD_POISON: begin
        if (poisoned) res = NEG_END;
      end
      default: res = raw;
    endcase
  end
endmodule

// File: rtl/ovf_out_stage.sv
module ovf_out_stage #(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  if (REG_OUT) begin : g_reg
    logic          full_q;
    logic [DW-1:0] data_q;

    assign up_ready = !full_q || dn_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (up_ready) begin
        full_q <= up_valid;
        if (up_valid) data_q <= up_data;
      end
    end

    assign dn_valid = full_q;
    assign dn_data  = data_q;
  end else begin : g_pass
    assign up_ready = dn_ready;
    assign dn_valid = up_valid;
    assign dn_data  = up_data;
  end
endmodule

// File: rtl/ovf_mode_adder.sv
module ovf_mode_adder
  import ovf_add_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry,
  output logic             out_ovf
);
  localparam int DW = WIDTH + 2;

  logic [WIDTH-1:0] raw_sum;
  logic [WIDTH-1:0] mode_sum;
  add_flags_t       raw_flags;
  logic [DW-1:0]    st_in;
  logic [DW-1:0]    st_out;

  ovf_ripple_core #(.WIDTH(WIDTH)) u_core (
    .a     (op_a),
    .b     (op_b),
    .sum   (raw_sum),
    .flags (raw_flags)
  );

  ovf_mode_mux #(.WIDTH(WIDTH)) u_mux (
    .mode  (mode),
    .a     (op_a),
    .b     (op_b),
    .raw   (raw_sum),
    .flags (raw_flags),
    .res   (mode_sum)
  );

  assign st_in = {mode_sum, raw_flags.carry, raw_flags.ovf};

  ovf_out_stage #(.DW(DW), .REG_OUT(REG_OUT)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (st_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (st_out)
  );

  assign out_sum   = st_out[DW-1:2];
  assign out_carry = st_out[1];
  assign out_ovf   = st_out[0];
endmodule

// File: rtl/ovf_mode_adder_chk.sv
module ovf_mode_adder_chk #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_sum,
  input logic             out_carry,
  input logic             out_ovf
);
  localparam logic [WIDTH-1:0] NEG_END = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] POS_END = {1'b0, {(WIDTH-1){1'b1}}};

  logic fire;
  assign fire = in_valid && in_ready;

  if (REG_OUT) begin : g_seq
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_carry) && $stable(out_ovf)); // R9
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R9
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid); // R9
    AST_NO_OPP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (op_a[WIDTH-1] != op_b[WIDTH-1]) |=> !out_ovf); // R3
    AST_CLAMP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      fire && mode == 2'b01 |=> !out_ovf || out_sum == NEG_END || out_sum == POS_END); // R4
    AST_POISON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fire && mode == 2'b10 && (op_a == NEG_END || op_b == NEG_END) |=> out_sum == NEG_END); // R6
    AST_POISON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      fire && mode == 2'b10 |=> !out_ovf || out_sum == NEG_END); // R5
  end
endmodule

bind ovf_mode_adder ovf_mode_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op_a      (op_a),
  .op_b      (op_b),
  .mode      (mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .out_carry (out_carry),
  .out_ovf   (out_ovf)
);

// File: tb/tb_ovf_mode_adder.sv
`timescale 1ns/1ps
module tb_ovf_mode_adder;
  localparam int W = 4;
  localparam real HALF = 10.0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [1:0]   mode = 2'b00;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_sum;
  logic         out_carry;
  logic         out_ovf;

  int n_run = 0;
  int n_fail = 0;

  always #(HALF) clk = ~clk;

  ovf_mode_adder #(.WIDTH(W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .mode(mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_carry(out_carry), .out_ovf(out_ovf)
  );

  // Reference model: returns {sum, carry, ovf}
  function automatic logic [W+1:0] ref_add(int a, int b, int m);
    int us, sa, sb, ss, w, r, lim, tok;
    logic c, v;
    lim = 1 << W;
    tok = 1 << (W - 1);
    us = a + b;
    c  = (us > lim - 1);
    w  = us % lim;
    sa = (a >= tok) ? a - lim : a;
    sb = (b >= tok) ? b - lim : b;
    ss = sa + sb;
    v  = (ss > tok - 1) || (ss < -tok);
    r  = w;
    if (m == 1 && v) r = (ss > 0) ? tok - 1 : tok;
    if (m == 2 && (a == tok || b == tok || v || w == tok)) r = tok;
    return {W'(r), c, v};
  endfunction

  function automatic string sum_tag(int m, int a, int b);
    int tok = 1 << (W - 1);
    if (m == 1) return "R4/R7";
    if (m == 2) return (a == tok || b == tok) ? "R6" : "R5/R7";
    return "R1";
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(int a, int b, int m);
    logic [W+1:0] e;
    e = ref_add(a, b, m);
    chk("R9 out_valid", int'(out_valid), 1);
    chk(sum_tag(m, a, b), int'(out_sum), int'(e[W+1:2]));
    chk("R2 carry", int'(out_carry), int'(e[1]));
    chk("R3 ovf", int'(out_ovf), int'(e[0]));
  endtask

  // drive one item, then check it one cycle later
  task automatic run_one(int a, int b, int m);
    @(negedge clk);
    op_a = W'(a); op_b = W'(b); mode = 2'(m); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(a, b, m);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R8 out_valid after reset", int'(out_valid), 0);
    chk("R8 in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after release", int'(out_valid), 0);

    // directed corners (R1, R2, R3, R5)
    run_one(15, 0, 0);   // R1: max wrap value, carry 0
    run_one(15, 15, 0);  // R1: 14 with carry 1
    run_one(15, 1, 0);   // R2/R3: -1+1 carry 1, no ovf
    run_one(13, 11, 2);  // R5: -3 + -5 lands on marker
    run_one(7, 1, 1);    // R4: positive clamp
    run_one(8, 15, 1);   // R4: negative clamp
    run_one(8, 0, 2);    // R6: marker plus zero

    // exhaustive sweep, all mode codes (R1..R7)
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_one(a, b, m);

    // seeded random items
    for (int k = 0; k < 300; k++)
      run_one(int'($urandom % 16), int'($urandom % 16), int'($urandom % 4));

    // back-pressure: R9
    @(negedge clk);
    op_a = 4'd3; op_b = 4'd4; mode = 2'b00; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check_out(3, 4, 0);
    op_a = 4'd6; op_b = 4'd6; mode = 2'b01; in_valid = 1'b1;
    chk("R9 in_ready low while stalled", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk("R9 held sum during stall", int'(out_sum), 7);
    chk("R9 still blocked", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(6, 6, 1);
    @(negedge clk);
    chk("R9 drained", int'(out_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule